// File: doc/BRIEF.md
# Vector Fused Multiply-Add Operand Steering and Result Merge

This block sits in front of and behind the arithmetic core of a 256-bit vector fused multiply-add unit. It accepts three 256-bit source operands and a decoded operation. A three-digit ordering code says which source plays the multiplicand, the multiplier and the addend. Two flags select one of the four sign forms: (x*y)+z, (x*y)-z, -(x*y)+z and -(x*y)-z. Further flags select single or double precision, scalar or packed mode, and for packed mode a 256-bit or a 128-bit vector width. The block routes the three roles to a per-lane arithmetic port. Negation is applied by flipping sign bits only. It also issues a mask of the active elements.

The arithmetic core returns one 256-bit word of per-element results. The block then builds the destination, which replaces the first source register. Active elements take the results. In scalar mode the other elements of the low 128 bits keep the first source's values. Everything else is cleared. An illegal ordering code skips the arithmetic. The first source comes back unchanged, with an error flag.

All three data interfaces use valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. A valid side holds its data stable until that edge. The block takes one operation at a time. `op_ready` is high only while the block is idle. `res_ready` is high only while an issued operation waits for its result. `iss_valid` and `dst_valid` stay high, with stable data, for as long as the consumer holds ready low.

Top module: `fma_steer_merge`

## Requirements
- R1: Ordering digits are 2 bits each: 2'b01 = first source, 2'b10 = second source, 2'b11 = third source. `op_order[5:4]` selects the multiplicand (`iss_mul_a`), `op_order[3:2]` the multiplier (`iss_mul_b`), `op_order[1:0]` the addend (`iss_addend`). The roles follow the code exactly and are never swapped.
- R2: Only the codes 132, 213 and 231 are legal. Any other code produces no issue. It returns `dst_data` equal to the first source with `dst_bad` = 1. Legal operations return `dst_bad` = 0.
- R3: `op_neg_prod` flips bit 31 (single) or bit 63 (double) of each active multiplicand element. `op_neg_add` does the same on the addend. All other bits, including NaN payloads, pass unchanged.
- R4: `iss_lane_en` bit k marks element k as active. Elements are 32 bits wide for single precision (`op_dbl` = 0) and 64 bits wide for double. Packed 256-bit mode (`op_wide` = 1) enables 8 single or 4 double elements.
- R5: Packed 128-bit mode (`op_wide` = 0, `op_scalar` = 0) enables half as many elements. It returns `dst_data[255:128]` = 0.
- R6: Scalar mode (`op_scalar` = 1) enables only element 0. The rest of `dst_data[127:0]` comes from the first source, and `dst_data[255:128]` = 0.
- R7: Active elements of `dst_data` equal the matching elements of the accepted `res_data`. Inactive packed elements are zero.
- R8: `op_ready` is high only when no operation is in flight, and never together with `iss_valid` or `dst_valid`.
- R9: While `iss_valid` is high and `iss_ready` is low, the issue outputs stay valid and unchanged.
- R10: `res_ready` is high only after issue and before the result is taken. `dst_valid` and `dst_data` hold until `dst_ready`.
- R11: After reset, `op_ready` = 1, and `iss_valid`, `dst_valid` and `res_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Block idle, request accepted |
| op_order | input | 6 | Three ordering digits, multiplicand digit in bits 5:4 |
| op_neg_prod | input | 1 | Negate the product |
| op_neg_add | input | 1 | Negate the addend |
| op_dbl | input | 1 | 1 = double precision, 0 = single |
| op_scalar | input | 1 | 1 = scalar, lowest element only |
| op_wide | input | 1 | Packed width: 1 = 256-bit, 0 = 128-bit |
| src1 | input | 256 | First source, also the destination register |
| src2 | input | 256 | Second source |
| src3 | input | 256 | Third source |
| iss_valid | output | 1 | Routed operands valid |
| iss_ready | input | 1 | Arithmetic core takes the operands |
| iss_mul_a | output | 256 | Multiplicand, sign-adjusted |
| iss_mul_b | output | 256 | Multiplier |
| iss_addend | output | 256 | Addend, sign-adjusted |
| iss_dbl | output | 1 | Element precision for the core |
| iss_lane_en | output | 8 | Active element mask |
| res_valid | input | 1 | Per-element results valid |
| res_ready | output | 1 | Block waits for results |
| res_data | input | 256 | Per-element results |
| dst_valid | output | 1 | Destination value valid |
| dst_ready | input | 1 | Destination consumer ready |
| dst_data | output | 256 | Merged destination value |
| dst_bad | output | 1 | Illegal ordering code |

## Verification
The assertions check the handshake rules on every cycle. They cover the hold of the issue and destination data under back-pressure and the exclusion between `op_ready` and the output valids. They also check that only legal codes issue, that scalar mode issues a single element, and that the upper half of a narrow or scalar destination is zero. The bench scenarios show the rest. These are the role mapping of each legal code, the exact position of each sign flip including on NaN patterns, the per-mode element masks, and the element-by-element merge of results with first-source data. They also show that illegal codes return the first source untouched.

// File: rtl/fma_sm_pkg.sv
package fma_sm_pkg;
  localparam int unsigned ELEM_W = 32;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ONE   = 2'd1,
    SRC_TWO   = 2'd2,
    SRC_THREE = 2'd3
  } src_sel_e;

  typedef struct packed {
    logic [5:0] order;
    logic       neg_prod;
    logic       neg_add;
    logic       dbl;
    logic       scalar;
    logic       wide;
  } fma_op_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } fsm_e;

  function automatic logic order_legal(input logic [5:0] o);
    return (o == 6'b01_11_10) || (o == 6'b10_01_11) || (o == 6'b10_11_01);
  endfunction
endpackage

// File: rtl/fma_lane_mask.sv
module fma_lane_mask #(
  parameter int unsigned LANES = 8
) (
  input  logic             dbl,
  input  logic             scalar,
  input  logic             wide,
  output logic [LANES-1:0] lane_en
);
  localparam int unsigned LANES_D = LANES / 2;

  int unsigned count;

  always_comb begin
    if (scalar) count = 1;
    else if (dbl) count = wide ? LANES_D : LANES_D / 2;
    else count = wide ? LANES : LANES / 2;
    for (int unsigned k = 0; k < LANES; k++) begin
      lane_en[k] = (k < count);
    end
  end
endmodule

// File: rtl/fma_route.sv
module fma_route
  import fma_sm_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned LANES = VEC_W / ELEM_W
) (
  input  logic [VEC_W-1:0] src1,
  input  logic [VEC_W-1:0] src2,
  input  logic [VEC_W-1:0] src3,
  input  src_sel_e         sel,
  input  logic             negate,
  input  logic             dbl,
  input  logic [LANES-1:0] lane_en,
  output logic [VEC_W-1:0] data_o
);
  logic [VEC_W-1:0] picked;

  always_comb begin
    unique case (sel)
      SRC_ONE:   picked = src1;
      SRC_TWO:   picked = src2;
      SRC_THREE: picked = src3;
      default:   picked = '0;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_slot
    logic flip;
    if (i % 2 == 1) begin : g_odd
      assign flip = negate & (dbl ? lane_en[i/2] : lane_en[i]);
    end else begin : g_even
      assign flip = negate & ~dbl & lane_en[i];
    end
    assign data_o[i*ELEM_W +: ELEM_W-1] = picked[i*ELEM_W +: ELEM_W-1];
    assign data_o[i*ELEM_W + ELEM_W-1]  = picked[i*ELEM_W + ELEM_W-1] ^ flip;
  end
endmodule

// File: rtl/fma_merge.sv
module fma_merge
  import fma_sm_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned LANES = VEC_W / ELEM_W
) (
  input  logic [VEC_W-1:0] src1,
  input  logic [VEC_W-1:0] res,
  input  logic             dbl,
  input  logic             scalar,
  input  logic [LANES-1:0] lane_en,
  output logic [VEC_W-1:0] dst
);
  localparam int unsigned LOW_SLOTS = 128 / ELEM_W;

  for (genvar i = 0; i < LANES; i++) begin : g_slot
    logic active;
    logic keep;
    assign active = dbl ? lane_en[i/2] : lane_en[i];
    assign keep   = scalar && (i < LOW_SLOTS);
    assign dst[i*ELEM_W +: ELEM_W] = active ? res[i*ELEM_W +: ELEM_W]
                                   : keep   ? src1[i*ELEM_W +: ELEM_W]
                                   : '0;
  end
endmodule

// File: rtl/fma_steer_merge.sv
module fma_steer_merge
  import fma_sm_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  localparam int unsigned LANES = VEC_W / ELEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [5:0]       op_order,
  input  logic             op_neg_prod,
  input  logic             op_neg_add,
  input  logic             op_dbl,
  input  logic             op_scalar,
  input  logic             op_wide,
  input  logic [VEC_W-1:0] src1,
  input  logic [VEC_W-1:0] src2,
  input  logic [VEC_W-1:0] src3,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [VEC_W-1:0] iss_mul_a,
  output logic [VEC_W-1:0] iss_mul_b,
  output logic [VEC_W-1:0] iss_addend,
  output logic             iss_dbl,
  output logic [LANES-1:0] iss_lane_en,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [VEC_W-1:0] res_data,
  output logic             dst_valid,
  input  logic             dst_ready,
  output logic [VEC_W-1:0] dst_data,
  output logic             dst_bad
);
  fsm_e             state_q;
  fma_op_t          op_q;
  logic [VEC_W-1:0] s1_q, s2_q, s3_q;
  logic [VEC_W-1:0] dst_q;
  logic             bad_q;
  logic             scl_q, wide_q;
  logic [VEC_W-1:0] routed [3];
  logic [VEC_W-1:0] merged;
  logic             op_fire, res_fire;

  assign op_ready  = (state_q == ST_IDLE);
  assign iss_valid = (state_q == ST_ISSUE);
  assign res_ready = (state_q == ST_WAIT);
  assign dst_valid = (state_q == ST_DONE);
  assign op_fire   = op_valid && op_ready;
  assign res_fire  = res_valid && res_ready;
  assign scl_q     = op_q.scalar;
  assign wide_q    = op_q.wide;

  fma_lane_mask #(.LANES(LANES)) u_mask (
    .dbl     (op_q.dbl),
    .scalar  (op_q.scalar),
    .wide    (op_q.wide),
    .lane_en (iss_lane_en)
  );

  for (genvar r = 0; r < 3; r++) begin : g_role
    logic neg;
    if (r == 0) begin : g_prod
      assign neg = op_q.neg_prod;
    end else if (r == 2) begin : g_add
      assign neg = op_q.neg_add;
    end else begin : g_plain
      assign neg = 1'b0;
    end
    fma_route #(.VEC_W(VEC_W), .LANES(LANES)) u_route (
      .src1    (s1_q),
      .src2    (s2_q),
      .src3    (s3_q),
      .sel     (src_sel_e'(op_q.order[5-2*r -: 2])),
      .negate  (neg),
      .dbl     (op_q.dbl),
      .lane_en (iss_lane_en),
      .data_o  (routed[r])
    );
  end

  assign iss_mul_a  = routed[0];
  assign iss_mul_b  = routed[1];
  assign iss_addend = routed[2];
  assign iss_dbl    = op_q.dbl;

  fma_merge #(.VEC_W(VEC_W), .LANES(LANES)) u_merge (
    .src1    (s1_q),
    .res     (res_data),
    .dbl     (op_q.dbl),
    .scalar  (op_q.scalar),
    .lane_en (iss_lane_en),
    .dst     (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      s1_q    <= '0;
      s2_q    <= '0;
      s3_q    <= '0;
      dst_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (op_fire) begin
          op_q  <= '{order: op_order, neg_prod: op_neg_prod, neg_add: op_neg_add,
                     dbl: op_dbl, scalar: op_scalar, wide: op_wide};
          s1_q  <= src1;
          s2_q  <= src2;
          s3_q  <= src3;
          bad_q <= !order_legal(op_order);
          if (order_legal(op_order)) begin
            state_q <= ST_ISSUE;
          end else begin
            dst_q   <= src1;
            state_q <= ST_DONE;
          end
        end
        ST_ISSUE: if (iss_ready) state_q <= ST_WAIT;
        ST_WAIT: if (res_fire) begin
          dst_q   <= merged;
          state_q <= ST_DONE;
        end
        ST_DONE: if (dst_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dst_data = dst_q;
  assign dst_bad  = bad_q;
endmodule

// File: rtl/fma_steer_merge_chk.sv
module fma_steer_merge_chk #(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_ready,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [VEC_W-1:0] iss_mul_a,
  input logic [VEC_W-1:0] iss_mul_b,
  input logic [VEC_W-1:0] iss_addend,
  input logic [LANES-1:0] iss_lane_en,
  input logic             res_ready,
  input logic             dst_valid,
  input logic             dst_ready,
  input logic [VEC_W-1:0] dst_data,
  input logic             dst_bad,
  input logic             bad_q,
  input logic             scl_q,
  input logic             wide_q
);
  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_mul_a) && $stable(iss_mul_b)
      && $stable(iss_addend) && $stable(iss_lane_en)); // R9
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready |=> dst_valid && $stable(dst_data) && $stable(dst_bad)); // R10
  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !iss_valid && !dst_valid && !res_ready); // R8
  AST_LEGAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !bad_q); // R2
  AST_SCALAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && scl_q |-> iss_lane_en == LANES'(1)); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_bad && (scl_q || !wide_q) |-> dst_data[VEC_W-1:VEC_W/2] == '0); // R5
  AST_RES_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_ready) |-> $past(iss_valid) && $past(iss_ready)); // R10
endmodule

bind fma_steer_merge fma_steer_merge_chk #(.VEC_W(VEC_W), .LANES(LANES)) chk_i (.*);

// File: tb/fma_steer_merge_tb_top.sv
module fma_steer_merge_tb_top;
  localparam int W = 256;
  localparam int L = 8;

  // {order[5:0], neg_prod, neg_add, dbl, scalar, wide}
  localparam logic [10:0] VECS [10] = '{
    {6'b01_11_10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {6'b10_01_11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {6'b10_11_01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {6'b01_11_10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {6'b10_01_11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {6'b10_11_01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {6'b10_11_01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {6'b01_10_11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {6'b11_01_10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {6'b00_00_00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, iss_ready = 0, res_valid = 0, dst_ready = 0;
  logic [5:0] op_order = '0;
  logic op_neg_prod = 0, op_neg_add = 0, op_dbl = 0, op_scalar = 0, op_wide = 0;
  logic [W-1:0] src1, src2, src3, res_data;
  logic op_ready, iss_valid, iss_dbl, res_ready, dst_valid, dst_bad;
  logic [W-1:0] iss_mul_a, iss_mul_b, iss_addend, dst_data;
  logic [L-1:0] iss_lane_en;

  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  fma_steer_merge dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pick(input logic [1:0] d);
    case (d)
      2'd1: return src1;
      2'd2: return src2;
      2'd3: return src3;
      default: return '0;
    endcase
  endfunction

  function automatic int n_active(input logic dbl, input logic scl, input logic wide);
    if (scl) return 1;
    return (dbl ? 4 : 8) / (wide ? 1 : 2);
  endfunction

  // sign of element k sits at the top bit of the element
  function automatic logic [W-1:0] negated(input logic [W-1:0] v, input logic dbl, input int n);
    logic [W-1:0] r = v;
    for (int k = 0; k < n; k++) begin
      if (dbl) r[64*k+63] = ~r[64*k+63];
      else     r[32*k+31] = ~r[32*k+31];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] merged(input logic dbl, input logic scl, input int n);
    logic [W-1:0] r = '0;
    int bits = n * (dbl ? 64 : 32);
    for (int b = 0; b < W; b++) begin
      if (b < bits) r[b] = res_data[b];
      else if (scl && b < 128) r[b] = src1[b];
    end
    return r;
  endfunction

  task automatic run_vec(input logic [10:0] v, input bit hold);
    logic [5:0] ord = v[10:5];
    logic np = v[4], na = v[3], dbl = v[2], scl = v[1], wide = v[0];
    bit legal = (ord == 6'b01_11_10) || (ord == 6'b10_01_11) || (ord == 6'b10_11_01);
    int n = n_active(dbl, scl, wide);
    logic [W-1:0] ea, eb, ec, sa;
    op_order = ord; op_neg_prod = np; op_neg_add = na;
    op_dbl = dbl; op_scalar = scl; op_wide = wide; op_valid = 1;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    op_valid = 0;
    if (!legal) begin
      while (!dst_valid) begin
        chk("R2 no issue", W'(iss_valid), W'(0));
        @(negedge clk);
      end
      chk("R2 bad flag", W'(dst_bad), W'(1));
      chk("R2 dst is src1", dst_data, src1);
    end else begin
      while (!iss_valid) @(negedge clk);
      ea = pick(ord[5:4]); eb = pick(ord[3:2]); ec = pick(ord[1:0]);
      if (np) ea = negated(ea, dbl, n);
      if (na) ec = negated(ec, dbl, n);
      chk("R1/R3 multiplicand", iss_mul_a, ea);
      chk("R1 multiplier", iss_mul_b, eb);
      chk("R1/R3 addend", iss_addend, ec);
      chk("R4/R5/R6 lane mask", W'(iss_lane_en), W'((1 << n) - 1));
      chk("R10 res_ready low during issue", W'(res_ready), W'(0));
      if (hold) begin
        sa = iss_mul_a;
        repeat (3) @(negedge clk);
        chk("R9 issue held", {iss_mul_a[W-2:0], iss_valid}, {sa[W-2:0], 1'b1});
      end
      iss_ready = 1;
      @(negedge clk);
      iss_ready = 0;
      res_valid = 1;
      while (!res_ready) @(negedge clk);
      @(negedge clk);
      res_valid = 0;
      chk("R7/R5/R6 merged dst", dst_data, merged(dbl, scl, n));
      chk("R2 good flag", W'(dst_bad), W'(0));
    end
    if (hold) begin
      sa = dst_data;
      res_data = ~res_data;
      repeat (3) @(negedge clk);
      chk("R10 dst held", dst_data, sa);
      chk("R8 op_ready low while dst pending", W'({op_ready, dst_valid}), W'(2'b01));
      res_data = ~res_data;
    end
    dst_ready = 1;
    @(negedge clk);
    dst_ready = 0;
    chk("R8 idle again", W'(op_ready), W'(1));
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      src1[32*k +: 32] = 32'h7FC1_0000 + k;
      src2[32*k +: 32] = 32'h7FA2_0000 + k;
      src3[32*k +: 32] = 32'h3F83_0000 + k;
      res_data[32*k +: 32] = 32'hC0D0_0000 + k;
    end
    repeat (2) @(negedge clk);
    chk("R11 op_ready", W'(op_ready), W'(1));
    chk("R11 valids", W'({iss_valid, dst_valid, res_ready}), W'(0));
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) run_vec(VECS[i], 1'b0);
    // back-pressure on both output sides
    run_vec(VECS[1], 1'b1);
    run_vec(VECS[7], 1'b1);
    // result offered early is not taken until issue completes
    res_valid = 1;
    run_vec(VECS[4], 1'b0);
    res_valid = 0;
    // NaN sign flip: a different single-precision pattern in all lanes
    src1 = {8{32'hFFC0_0001}};
    src3 = {8{32'h7F80_0003}};
    run_vec(VECS[6], 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule